// File: doc/BRIEF.md
# Q14 Fixed-Point Butterfly Multiplier

This unit does the multiply-and-narrow steps that make up the rotations and butterflies of an integer inverse transform. A single transaction carries eight signed 16-bit lanes on each of two vector operands, `a_vec` and `b_vec`, together with two signed 16-bit constants. The 2-bit opcode selects one of four operations. The chosen operation runs on all eight lanes in parallel, and each lane is independent of the others.

Every operation ends the same way. The product is rounded half-up at bit 13, shifted arithmetically right by 14 and reduced to 16 bits. The single-input scale uses a constant doubled to 16 bits and keeps the rounded high half of a doubled product, which saturates. The add and subtract forms widen the operands before combining them, so large inputs do not lose their carry. Their product is then kept modulo 2^32 and the result is truncated to 16 bits. The dual multiply-accumulate form does the same. The surrounding transform controller sequences the stages and supplies the cosine constants.

Results are registered with a valid/ready handshake on both sides. An accepted operation appears at the output on the next cycle. The output stays put for as long as the consumer stalls.

Top module: `q14_bfly_unit`

## Requirements
- R1: While `rst_n` is low and right after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: Opcode 0 (scale) gives, per lane, round((2·a·d + 2^15) / 2^16) with floor division. Here d is `k1`·2 wrapped to signed 16 bits. For |k1| ≤ 16383 this equals (a·k1 + 2^13) >> 14.
- R3: Opcode 0 saturates to [-32768, 32767]. For example a = -32768 with k1 = -16384 gives 32767.
- R4: Opcode 1 forms a + b exactly (no 16-bit wrap of the sum). It multiplies the sum by `k1` modulo 2^32, then applies (p + 2^13) >>> 14 and keeps the low 16 bits.
- R5: Opcode 2 works like opcode 1 on a − b, with the first operand `a_vec` minus the second `b_vec`.
- R6: Opcode 3 forms a·k1 + b·k2 modulo 2^32, then applies (p + 2^13) >>> 14 and keeps the low 16 bits.
- R7: Rounding is half-up. A value of exactly x.5 in units of 2^14 goes toward +infinity, so −0.5 becomes 0 and −1.5 becomes −1.
- R8: Opcodes 1–3 narrow by truncation without saturation. A rounded value of 131064 gives 0xFFF8.
- R9: Lane l occupies bits [16l+15:16l] of `a_vec`, `b_vec` and `y_vec`. Each lane's result depends only on that lane's operands and the shared constants.
- R10: A transfer accepted at a clock edge (`in_valid` and `in_ready` both high) makes `out_valid` 1 after that edge. `out_valid` never rises without such a transfer.
- R11: While `out_valid` is 1 and `out_ready` is 0, `y_vec` and `out_valid` stay unchanged on the next edge and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| op_sel | input | 2 | 0 scale, 1 add-scale, 2 subtract-scale, 3 dual multiply-accumulate |
| a_vec | input | 128 | First operand, eight signed 16-bit lanes |
| b_vec | input | 128 | Second operand, eight signed 16-bit lanes |
| k1 | input | 16 | Signed constant for the first operand or the combined value |
| k2 | input | 16 | Signed constant for the second operand (opcode 3) |
| out_valid | output | 1 | Result held on `y_vec` |
| out_ready | input | 1 | Consumer takes the result |
| y_vec | output | 128 | Eight signed 16-bit results |

## Verification
A fault in the lane arithmetic shows up as a wrong lane value in the item that leaves the output register one cycle after acceptance. The scoreboard reports it on the first transfer that uses the affected opcode and operand range. Directed cases cover saturation, wide sums, 32-bit wrap and half-up ties, so those corners do not depend on random stimulus. A fault in the hold register shows up within one stalled cycle, either as a result that changes while `out_ready` is low or as `in_ready` staying high during the stall. A lost or duplicated item shows up as a scoreboard mismatch or an empty-queue pop at the next transfer.

// File: rtl/q14_bfly_pkg.sv
package q14_bfly_pkg;

    typedef enum logic [1:0] {
        OP_SCALE     = 2'd0,
        OP_ADD_SCALE = 2'd1,
        OP_SUB_SCALE = 2'd2,
        OP_DUAL_MAC  = 2'd3
    } bfly_op_e;

endpackage

// File: rtl/q14_bfly_lane.sv
module q14_bfly_lane
    import q14_bfly_pkg::*;
#(
    parameter int W    = 16,
    parameter int FRAC = 14
) (
    input  bfly_op_e              op,
    input  logic signed [W-1:0]   a,
    input  logic signed [W-1:0]   b,
    input  logic signed [W-1:0]   k1,
    input  logic signed [W-1:0]   k2,
    output logic signed [W-1:0]   y
);
    localparam int PW = 2 * W;
    localparam logic signed [PW:0] RND_LO = (PW+1)'(1) <<< (FRAC - 1);
    localparam logic signed [PW:0] RND_HI = (PW+1)'(1) <<< (W - 1);
    localparam logic signed [PW:0] SAT_HI = (PW+1)'((64'sd1 <<< (W - 1)) - 64'sd1);
    localparam logic signed [PW:0] SAT_LO = -SAT_HI - (PW+1)'(1);

    // rounded arithmetic shift of a PW-bit value, low W bits kept
    function automatic logic signed [W-1:0] round_narrow(input logic signed [PW-1:0] x);
        logic signed [PW:0] t;
        t = (PW+1)'(x) + RND_LO;
        t = t >>> FRAC;
        return W'(t);
    endfunction

    logic signed [W-1:0]  k1_dbl;
    logic signed [PW-1:0] prod_sc;
    logic signed [PW:0]   dbl_sc;
    logic signed [PW:0]   hi_sc;
    logic signed [W-1:0]  y_sc;
    logic signed [W:0]    ab_wide;
    logic signed [PW-1:0] prod_ab;
    logic signed [PW-1:0] prod_mac;

    // single-input path: doubled constant, rounded high half, saturation
    always_comb begin
        k1_dbl  = {k1[W-2:0], 1'b0};
        prod_sc = PW'(a) * PW'(k1_dbl);
        dbl_sc  = {prod_sc, 1'b0};
        hi_sc   = (dbl_sc + RND_HI) >>> W;
        if (hi_sc > SAT_HI)
            y_sc = W'(SAT_HI);
        else if (hi_sc < SAT_LO)
            y_sc = W'(SAT_LO);
        else
            y_sc = W'(hi_sc);
    end

    // widened add/subtract, then scale, 32-bit wrap
    always_comb begin
        if (op == OP_SUB_SCALE)
            ab_wide = (W+1)'(a) - (W+1)'(b);
        else
            ab_wide = (W+1)'(a) + (W+1)'(b);
        prod_ab  = PW'(ab_wide) * PW'(k1);
        prod_mac = PW'(a) * PW'(k1) + PW'(b) * PW'(k2);
    end

    always_comb begin
        unique case (op)
            OP_SCALE:     y = y_sc;
            OP_ADD_SCALE,
            OP_SUB_SCALE: y = round_narrow(prod_ab);
            default:      y = round_narrow(prod_mac);
        endcase
    end

endmodule

// File: rtl/q14_bfly_hold.sv
module q14_bfly_hold #(
    parameter int DW = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] dat;
    } hold_t;

    hold_t st_d, st_q;
    logic  take;

    always_comb begin
        st_d     = st_q;
        in_ready = !st_q.vld || out_ready;
        take     = in_valid && in_ready;
        if (take) begin
            st_d.vld = 1'b1;
            st_d.dat = in_data;
        end else if (st_q.vld && out_ready) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.dat;

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R11
    stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R10
    accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R10
    valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready));

endmodule

// File: rtl/q14_bfly_unit.sv
module q14_bfly_unit
    import q14_bfly_pkg::*;
#(
    parameter int LANES = 8,
    parameter int W     = 16,
    parameter int FRAC  = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [1:0]           op_sel,
    input  logic [LANES*W-1:0]   a_vec,
    input  logic [LANES*W-1:0]   b_vec,
    input  logic [W-1:0]         k1,
    input  logic [W-1:0]         k2,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [LANES*W-1:0]   y_vec
);
    localparam int VW = LANES * W;

    bfly_op_e      op;
    logic [VW-1:0] res_d;

    assign op = bfly_op_e'(op_sel);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic signed [W-1:0] lane_y;
        q14_bfly_lane #(.W(W), .FRAC(FRAC)) u_lane (
            .op (op),
            .a  ($signed(a_vec[l*W +: W])),
            .b  ($signed(b_vec[l*W +: W])),
            .k1 ($signed(k1)),
            .k2 ($signed(k2)),
            .y  (lane_y)
        );
        assign res_d[l*W +: W] = lane_y;
    end

    q14_bfly_hold #(.DW(VW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (res_d),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (y_vec)
    );

endmodule

// File: tb/q14_bfly_unit_test.sv
module q14_bfly_unit_test;
    localparam int LANES = 8;
    localparam int W     = 16;
    localparam int VW    = LANES * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [1:0]    op_sel = '0;
    logic [VW-1:0] a_vec = '0;
    logic [VW-1:0] b_vec = '0;
    logic [W-1:0]  k1 = '0;
    logic [W-1:0]  k2 = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [VW-1:0] y_vec;

    int n_checks = 0;
    int n_fail   = 0;
    int ready_pct = 100;
    bit acc_flag = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [VW-1:0] y;
        string         tag;
    } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;

    q14_bfly_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op_sel(op_sel), .a_vec(a_vec), .b_vec(b_vec), .k1(k1), .k2(k2),
        .out_valid(out_valid), .out_ready(out_ready), .y_vec(y_vec)
    );

    task automatic check(input bit ok, input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_lane(input int op, input int a, input int b, input int c1, input int c2);
        longint p, r;
        int     d, s, w32;
        if (op == 0) begin
            d = c1 * 2;
            if (d > 32767) d -= 65536;
            if (d < -32768) d += 65536;
            p = longint'(2) * a * d;
            r = (p + 32768) >>> 16;
            if (r > 32767) r = 32767;
            if (r < -32768) r = -32768;
        end else begin
            if (op == 3) w32 = int'(longint'(a) * c1 + longint'(b) * c2);
            else begin
                s   = (op == 1) ? a + b : a - b;
                w32 = int'(longint'(s) * c1);
            end
            r = (longint'(w32) + 8192) >>> 14;
        end
        return r[15:0];
    endfunction

    task automatic send(input int op, input logic [VW-1:0] av, input logic [VW-1:0] bv,
                        input int c1, input int c2, input string tag);
        item_t it;
        bit    ok;
        for (int l = 0; l < LANES; l++)
            it.y[l*W +: W] = ref_lane(op, int'($signed(av[l*W +: W])), int'($signed(bv[l*W +: W])), c1, c2);
        it.tag   = tag;
        op_sel   = 2'(op);
        a_vec    = av;
        b_vec    = bv;
        k1       = 16'(c1);
        k2       = 16'(c2);
        in_valid = 1'b1;
        do begin
            #11;
            ok = in_ready;
            if (ok) begin
                exp_q.push_back(it);
                acc_flag = 1'b1;
            end
            @(posedge clk);
            #4;
        end while (!ok);
        in_valid = 1'b0;
    endtask

    function automatic logic [VW-1:0] pack8(input int v0, input int v1, input int v2, input int v3,
                                            input int v4, input int v5, input int v6, input int v7);
        return {16'(v7), 16'(v6), 16'(v5), 16'(v4), 16'(v3), 16'(v2), 16'(v1), 16'(v0)};
    endfunction

    // monitor: sets out_ready, checks latency, stall hold and scoreboard
    initial begin
        bit            prev_stall = 1'b0;
        logic [VW-1:0] prev_y = '0;
        item_t         it;
        forever begin
            @(posedge clk);
            #2;
            out_ready = ($urandom_range(99) < ready_pct);
            #8;
            if (rst_n) begin
                if (acc_flag) begin
                    // R10: valid one edge after acceptance
                    check(out_valid === 1'b1, "R10 latency", VW'(out_valid), VW'(1));
                    acc_flag = 1'b0;
                end
                if (prev_stall) begin
                    // R11: held result
                    check(out_valid === 1'b1 && y_vec === prev_y, "R11 hold", y_vec, prev_y);
                end
                if (out_valid && !out_ready) begin
                    // R11: input side blocked
                    check(in_ready === 1'b0, "R11 in_ready", VW'(in_ready), VW'(0));
                end
                prev_stall = out_valid && !out_ready;
                prev_y     = y_vec;
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R10 unexpected item", y_vec, '0);
                    end else begin
                        it = exp_q.pop_front();
                        check(y_vec === it.y, it.tag, y_vec, it.y);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // driver
    initial begin
        logic [VW-1:0] ra, rb;
        int            rop, rc1, rc2;
        repeat (3) @(posedge clk);
        #5;
        // R1: reset state
        check(out_valid === 1'b0, "R1 out_valid in reset", VW'(out_valid), VW'(0));
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        #9;
        check(out_valid === 1'b0 && in_ready === 1'b1, "R1 after reset",
              VW'({out_valid, in_ready}), VW'(2'b01));
        @(posedge clk);
        #4;

        send(0, pack8(1000, -1000, 32767, -32768, 12345, 0, 7, -7),
             '0, 11585, 0, "R2 scale");
        send(0, pack8(-32768, 32767, -32768, 100, -100, 20000, -20000, 1),
             '0, -16384, 0, "R3 saturation");
        send(1, pack8(30000, 30000, -30000, 32767, -32768, 100, 0, 5),
             pack8(30000, 2767, -30000, 32767, -32768, -100, 1, -5),
             11585, 0, "R4 widened add");
        send(2, pack8(-30000, 30000, 32767, -32768, 5, 0, 100, -1),
             pack8(30000, -30000, -32768, 32767, 5, 1, -100, 1),
             15137, 0, "R5 subtract order");
        send(3, pack8(-32768, 32767, 1000, -1000, 0, 12, -32768, 300),
             pack8(-32768, 32767, -1000, 1000, 7, -12, 32767, 301),
             -32768, -32768, "R6 dual mac");
        send(3, pack8(1234, 2, -3, 4, 5, 6, 7, 8),
             pack8(-4321, 9, 10, -11, 12, 13, 14, 15),
             6270, -15137, "R6 dual mac mixed");
        send(1, pack8(1, -1, 3, -3, 5, -5, 0, 2),
             '0, 8192, 0, "R7 half-up ties");
        send(3, pack8(32767, 32767, -32768, 1, 32767, 0, 0, 0),
             pack8(32767, -32768, -32768, 1, 0, 0, 0, 0),
             32767, 32767, "R8 truncating narrow");
        send(2, pack8(1, 2, 3, 4, 5, 6, 7, 8),
             pack8(-8, -7, -6, -5, -4, -3, -2, -1),
             16364, 0, "R9 lane placement");

        ready_pct = 60;
        for (int i = 0; i < 400; i++) begin
            rop = $urandom_range(3);
            for (int l = 0; l < LANES; l++) begin
                ra[l*W +: W] = (i % 2 == 0) ? 16'($urandom) : 16'(int'($urandom_range(510)) - 255);
                rb[l*W +: W] = (i % 3 == 0) ? 16'($urandom) : 16'(int'($urandom_range(510)) - 255);
            end
            rc1 = int'($urandom_range(32766)) - 16383;
            rc2 = int'($urandom_range(32766)) - 16383;
            case (rop)
                0: send(rop, ra, rb, rc1, rc2, "R2 random scale");
                1: send(rop, ra, rb, rc1, rc2, "R4 random add");
                2: send(rop, ra, rb, rc1, rc2, "R5 random sub");
                default: send(rop, ra, rb, rc1, rc2, "R6 random mac");
            endcase
            if ($urandom_range(3) == 0) begin
                @(posedge clk);
                #4;
            end
        end

        ready_pct = 100;
        while (exp_q.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule